// File: doc/BRIEF.md
# User Data Buffer Serializer

This block holds eight byte-wide locations that a host reaches through a simple parallel port. The lower half holds one read-only status byte and three control bytes. The upper half holds four user-data bytes. A second, internal read port walks the user-data bytes in a fixed cycle. It turns them into a stream of single user bits, one bit for each audio sample. A sample here means one channel, not a stereo pair.

On the first sample strobe of a byte, the serializer reads the location under its pointer. It emits bit 0 of that byte at once and parks the remaining bits in a shift register, which shifts them out on the next seven strobes. The pointer then moves to the next user location. After the fourth byte it returns to the first, so the pattern in the buffer repeats every 32 samples. The host may rewrite any user byte at any time. A byte already captured by the serializer is never disturbed by such a write.

Top module: `ubuf_serializer`

## Requirements
- R1: After reset, `ubit` is 0 and every location, including the status byte at address 0, reads as 0x00.
- R2: A host write (`host_we`=1) to addresses 1 to 7 is returned by a later host read of that address on `host_rdata`. The read is combinational from `host_addr`.
- R3: Host writes to address 0 have no effect on the status byte or on the serial output.
- R4: `ubit` changes only in the cycle after a clock edge at which `smp_stb` was 1. It holds its value through cycles without a strobe.
- R5: Counting strobes from reset as k = 0, 1, 2, ..., strobe k drives `ubit` to bit (k mod 8) of user location 4 + ((k div 8) mod 4). Bits go out LSB first.
- R6: After 8 strobes on one user location, the serializer moves to the next address, in the order 4, 5, 6, 7.
- R7: After location 7 has been sent (32 strobes), the serializer wraps back to location 4.
- R8: If a host write to the location about to be loaded happens at the same edge as the loading strobe, the old value is sent in this pass and the new value in the next pass.
- R9: The status byte at address 0 reports the byte index (location minus 4) in bits 1:0 and the number of bits of that byte already sent in bits 4:2. Bits 7:5 read 0.
- R10: A host write to the user location being shifted out, made in the middle of a byte, does not alter the remaining bits of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe per single-channel audio sample |
| host_we | input | 1 | Host write enable |
| host_addr | input | 3 | Host location address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| ubit | output | 1 | Current user bit for the outgoing subframe |

## Verification
The hardest case to reach from the ports is a host write that lands on the exact edge where the serializer loads that same location. The bench gets there by counting strobes from reset so that it knows when the bit count is zero. It then raises the strobe and the write to the current location in the same cycle. After that, it runs a full 32-sample pass to show that the new value appears only on the next visit. A write in the middle of a byte is covered the same way, and the status byte confirms the position of the serializer.

// File: rtl/ubuf_serializer.sv
`timescale 1ns/1ps
module ubuf_serializer #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          ubit
);
  localparam int NLOC = 1 << AW;
  localparam int PW   = AW - 1;
  localparam int CW   = $clog2(DW);

  logic [DW-1:0] loc [NLOC];
  logic [PW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          ubit_q;
  logic [DW-1:0] cur_byte;
  logic [DW-1:0] status;

  assign status     = {{(DW-CW-PW){1'b0}}, cnt, ptr};
  assign cur_byte   = loc[{1'b1, ptr}];
  assign host_rdata = loc[host_addr];
  assign ubit       = ubit_q;

  for (genvar i = 0; i < NLOC; i++) begin : g_loc
    if (i == 0) begin : g_stat
      assign loc[i] = status;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          loc[i] <= '0;
        else if (host_we && host_addr == AW'(i))
          loc[i] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr    <= '0;
      cnt    <= '0;
      shreg  <= '0;
      ubit_q <= 1'b0;
    end else if (smp_stb) begin
      if (cnt == '0) begin
        ubit_q <= cur_byte[0];
        shreg  <= cur_byte >> 1;
      end else begin
        ubit_q <= shreg[0];
        shreg  <= shreg >> 1;
      end
      if (cnt == CW'(DW-1)) begin
        cnt <= '0;
        ptr <= PW'(ptr + 1'b1);
      end else begin
        cnt <= CW'(cnt + 1'b1);
      end
    end
endmodule

module ubuf_serializer_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stb,
  input logic            ubit,
  input logic [AW-2:0]   ptr,
  input logic [$clog2(DW)-1:0] cnt,
  input logic            cur_lsb,
  input logic [DW-1:0]   status
);
  localparam int PW = AW - 1;
  localparam int CW = $clog2(DW);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(ubit));

  p_load_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && cnt == '0) |=> ubit == $past(cur_lsb));

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && cnt == CW'(DW-1)) |=> (ptr == PW'($past(ptr) + 1'b1) && cnt == '0));

  p_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && cnt != CW'(DW-1)) |=> ptr == $past(ptr));

  p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(status));
endmodule

bind ubuf_serializer ubuf_serializer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(smp_stb), .ubit(ubit),
  .ptr(ptr), .cnt(cnt), .cur_lsb(cur_byte[0]), .status(status)
);

// File: tb/sim_ubuf_serializer.sv
`timescale 1ns/1ps
module sim_ubuf_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       ubit;

  int checks = 0;
  int errors = 0;
  int nstb = 0;

  always #2.5 clk = ~clk;

  ubuf_serializer u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ubit(ubit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    smp_stb = s; host_we = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    smp_stb = 1'b0; host_we = 1'b0;
    if (s) nstb++;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_stb = 1'b0; host_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nstb = 0;
  endtask

  function automatic logic [7:0] st_exp(input int n);
    return 8'(((n % 8) << 2) | ((n / 8) % 4));
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk(ubit == 1'b0, "R1 ubit", ubit, 0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk(v == 8'h00, "R1 location", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] v;
    do_reset();
    for (int i = 1; i < 8; i++) cyc(1'b0, 1'b1, 3'(i), 8'(8'h11 * i + 8'h20));
    for (int i = 1; i < 8; i++) begin
      rd(3'(i), v);
      chk(v == 8'(8'h11 * i + 8'h20), "R2 readback", v, 8'(8'h11 * i + 8'h20));
    end
    cyc(1'b0, 1'b1, 3'd0, 8'hFF);
    rd(3'd0, v);
    chk(v == 8'h00, "R3 status write ignored", v, 0);
    chk(ubit == 1'b0, "R3 ubit untouched", ubit, 0);
  endtask

  task automatic t_stream();
    logic [7:0] b [4];
    logic [7:0] v;
    b[0] = 8'hA5; b[1] = 8'h3C; b[2] = 8'hF0; b[3] = 8'h81;
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 3'(4 + i), b[i]);
    for (int k = 0; k < 40; k++) begin
      cyc(1'b1, 1'b0, 3'd0, 8'h00);
      chk(ubit == b[(k / 8) % 4][k % 8], k < 32 ? "R5/R6 bit order" : "R7 wrap bit",
          ubit, b[(k / 8) % 4][k % 8]);
      if (k == 7 || k == 10 || k == 31 || k == 37) begin
        rd(3'd0, v);
        chk(v == st_exp(nstb), k == 31 ? "R7 status wrap" : "R9 status", v, st_exp(nstb));
      end
    end
  endtask

  task automatic t_hold();
    logic held;
    do_reset();
    cyc(1'b0, 1'b1, 3'd4, 8'h01);
    cyc(1'b1, 1'b0, 3'd0, 8'h00);
    chk(ubit == 1'b1, "R5 first bit", ubit, 1);
    held = ubit;
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 1'b1, 3'd4, 8'h00);
      chk(ubit == held, "R4 hold without strobe", ubit, held);
    end
  endtask

  task automatic t_collision();
    do_reset();
    cyc(1'b0, 1'b1, 3'd4, 8'h00);
    cyc(1'b1, 1'b1, 3'd4, 8'hFF);
    chk(ubit == 1'b0, "R8 old value bit0", ubit, 0);
    for (int k = 1; k < 8; k++) begin
      cyc(1'b1, 1'b0, 3'd0, 8'h00);
      chk(ubit == 1'b0, "R8 old value rest", ubit, 0);
    end
    for (int k = 8; k < 32; k++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 1'b0, 3'd0, 8'h00);
      chk(ubit == 1'b1, "R8 new value next pass", ubit, 1);
    end
  endtask

  task automatic t_midbyte();
    logic [7:0] old;
    old = 8'h0F;
    do_reset();
    cyc(1'b0, 1'b1, 3'd4, old);
    cyc(1'b1, 1'b0, 3'd0, 8'h00);
    cyc(1'b1, 1'b0, 3'd0, 8'h00);
    cyc(1'b0, 1'b1, 3'd4, 8'hF0);
    for (int k = 2; k < 8; k++) begin
      cyc(1'b1, 1'b0, 3'd0, 8'h00);
      chk(ubit == old[k], "R10 midbyte write", ubit, old[k]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_stream();
    t_hold();
    t_collision();
    t_midbyte();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule